// File: doc/BRIEF.md
# Pipelined Parallel-Prefix Adder

This block adds two unsigned operands of 16 bits with a four-stage pipeline. The carries come from a logarithmic prefix tree, not a ripple chain. The tree is built only from two-input AND, OR and XOR operations. A caller presents the operands together with a qualifying flag. Exactly four cycles later the sum, the carry-out and a matching result flag appear at the outputs. A new addition can enter on every clock, so one result leaves per cycle once the pipe is full.

The pipeline is cut as follows:

1. The first stage registers the per-bit propagate and generate terms.
2. The second stage runs the prefix levels of span 1 and 2.
3. The third stage runs the levels of span 4 and 8. Its output already holds the final carry out of every bit position, including the word carry-out.
4. The last stage combines those carries with the bitwise propagate terms to form the sum.

There is no carry input and no subtract mode. Reset is asynchronous and active-low. It is released through a two-flop synchroniser and empties the pipeline.

Top module: `pfx_adder16`

## Requirements
- R1: For every accepted operation, `{carry_out, sum_out}` equals the 17-bit unsigned sum of `a_in` and `b_in` taken from the cycle the operation was accepted.
- R2: `out_valid` is high in a given cycle exactly when `in_valid` was high four cycles earlier. Operations may be accepted on consecutive cycles.
- R3: Propagate for bit i is `a_in[i] XOR b_in[i]` and generate is `a_in[i] AND b_in[i]`. The carry into bit 0 is 0, so operands with no generate term give `sum_out = a_in XOR b_in` and `carry_out = 0`.
- R4: After the span-1 and span-2 levels (end of stage 2), the group-generate term of bit 3 equals the carry out of the low four bits.
- R5: The word carry-out is formed by the end of stage 3 and equals bit 16 of the full sum.
- R6: While reset is asserted, and afterwards until a new operation has crossed the pipe, `out_valid` is 0. Operations in flight when reset is asserted never emerge.
- R7: A cycle with `in_valid` low neither loads the first stage nor disturbs results already in flight. Four cycles later that cycle shows `out_valid` low.
- R8: A carry that ripples through all 16 positions is resolved: 0xFFFF + 0x0001 gives `sum_out = 0x0000` and `carry_out = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are to be added this cycle |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| out_valid | output | 1 | `sum_out`/`carry_out` hold a result |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Bit 16 of the sum |

## Verification
Several operand classes are used, and each separates a different fault:
- All-zero operands and complementary pairs such as 0x5555 + 0xAAAA have no generate term anywhere, so they test the propagate XOR path on its own.
- Operands that carry out of the low nibble, out of a byte, out of bit 15 or through the whole word each need a different prefix span to reach the sum. A missing or mis-spanned level therefore shows up on only some of them.
- A random stream with idle gaps checks the valid alignment and the clock enables against a behavioural addition model.
- Reset asserted mid-stream shows that operations already in flight are dropped.

// File: rtl/pfx_add_pkg.sv
package pfx_add_pkg;
  localparam int unsigned PFX_W_DEFAULT = 16;
endpackage

// File: rtl/pfx_rst_sync.sv
module pfx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pfx_pg_gen.sv
module pfx_pg_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  always_comb begin
    p = a ^ b;
    g = a & b;
  end
endmodule

// File: rtl/pfx_prefix_level.sv
// One prefix level: each position at or above SPAN merges with position i-SPAN.
module pfx_prefix_level #(
  parameter int W    = 16,
  parameter int SPAN = 1
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] g_out,
  output logic [W-1:0] p_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= SPAN) begin : g_merge
      logic pg_and;
      assign pg_and   = p_in[i] & g_in[i-SPAN];
      assign g_out[i] = g_in[i] | pg_and;
      assign p_out[i] = p_in[i] & p_in[i-SPAN];
    end else begin : g_pass
      assign g_out[i] = g_in[i];
      assign p_out[i] = p_in[i];
    end
  end
endmodule

// File: rtl/pfx_level_group.sv
// NLEV chained prefix levels with spans FIRST_SPAN, 2*FIRST_SPAN, ...
module pfx_level_group #(
  parameter int W          = 16,
  parameter int FIRST_SPAN = 1,
  parameter int NLEV       = 2
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] g_out,
  output logic [W-1:0] p_out
);
  logic [NLEV:0][W-1:0] g_chain;
  logic [NLEV:0][W-1:0] p_chain;

  assign g_chain[0] = g_in;
  assign p_chain[0] = p_in;

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lvl
    pfx_prefix_level #(
      .W   (W),
      .SPAN(FIRST_SPAN << lv)
    ) u_level (
      .g_in (g_chain[lv]),
      .p_in (p_chain[lv]),
      .g_out(g_chain[lv+1]),
      .p_out(p_chain[lv+1])
    );
  end

  assign g_out = g_chain[NLEV];
  assign p_out = p_chain[NLEV];
endmodule

// File: rtl/pfx_adder16.sv
module pfx_adder16 #(
  parameter int W = pfx_add_pkg::PFX_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);
  localparam int LEVELS  = $clog2(W);
  localparam int LV_S2   = LEVELS / 2;
  localparam int LV_S3   = LEVELS - LV_S2;
  localparam int SPAN_S3 = 1 << LV_S2;

  logic rst_n_s;

  pfx_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  // Stage 1: bit propagate / generate
  logic [W-1:0] p1_d, g1_d, p1_q, g1_q;
  logic         v1_d, v1_q;

  pfx_pg_gen #(.W(W)) u_pg (
    .a(a_in), .b(b_in), .p(p1_d), .g(g1_d)
  );

  // Stage 2: spans 1 and 2
  logic [W-1:0] g2_d, pp2_d, g2_q, pp2_q, praw2_q;
  logic         v2_d, v2_q;

  pfx_level_group #(.W(W), .FIRST_SPAN(1), .NLEV(LV_S2)) u_grp_s2 (
    .g_in (g1_q), .p_in (p1_q),
    .g_out(g2_d), .p_out(pp2_d)
  );

  // Stage 3: spans 4 and 8, carries for every position
  logic [W-1:0] c3_d, pp3_d, c3_q, praw3_q;
  logic         v3_d, v3_q;

  pfx_level_group #(.W(W), .FIRST_SPAN(SPAN_S3), .NLEV(LV_S3)) u_grp_s3 (
    .g_in (g2_q), .p_in (pp2_q),
    .g_out(c3_d), .p_out(pp3_d)
  );

  // Stage 4: sum
  logic [W-1:0] sum_d, sum_q;
  logic         cout_d, cout_q, v4_d, v4_q;

  // Next-state logic
  always_comb begin
    v1_d   = in_valid;
    v2_d   = v1_q;
    v3_d   = v2_q;
    v4_d   = v3_q;
    sum_d  = praw3_q ^ {c3_q[W-2:0], 1'b0};
    cout_d = c3_q[W-1];
  end

  // Valid chain: the only reset state
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      v4_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      v3_q <= v3_d;
      v4_q <= v4_d;
    end
  end

  // Data registers, each loaded only under its stage enable
  always_ff @(posedge clk) begin
    if (v1_d) begin
      p1_q <= p1_d;
      g1_q <= g1_d;
    end
    if (v2_d) begin
      g2_q    <= g2_d;
      pp2_q   <= pp2_d;
      praw2_q <= p1_q;
    end
    if (v3_d) begin
      c3_q    <= c3_d;
      praw3_q <= praw2_q;
    end
    if (v4_d) begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  assign out_valid = v4_q;
  assign sum_out   = sum_q;
  assign carry_out = cout_q;

  // R1: full result four cycles after acceptance
  a_r1_result: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> ({carry_out, sum_out} ==
                   ({1'b0, $past(a_in, 4)} + {1'b0, $past(b_in, 4)})));

  // R2: valid latency is exactly four cycles
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid |-> ##4 out_valid);

  // R7: an idle cycle yields an idle output slot
  a_r7_idle_slot: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_valid |-> ##4 !out_valid);

  // R7: stage 1 holds while no operation is accepted
  a_r7_s1_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_valid |=> ($stable(p1_q) && $stable(g1_q)));

  // R3: the whole-word group propagate after all levels is the AND of bit propagates
  a_r3_word_propagate: assert property (@(posedge clk) disable iff (!rst_n_s)
    v2_q |-> (pp3_d[W-1] == (&praw2_q)));

  // R4: low-nibble carry resolved after spans 1 and 2
  a_r4_nibble_carry: assert property (@(posedge clk) disable iff (!rst_n_s)
    v2_q |-> ({g2_q[3], 4'b0000} ==
              (({1'b0, $past(a_in[3:0], 2)} + {1'b0, $past(b_in[3:0], 2)}) & 5'b10000)));

  // R5: word carry-out present at the end of stage 3
  a_r5_cout_stage3: assert property (@(posedge clk) disable iff (!rst_n_s)
    v3_q |-> ({c3_q[W-1], {W{1'b0}}} ==
              (({1'b0, $past(a_in, 3)} + {1'b0, $past(b_in, 3)}) & {1'b1, {W{1'b0}}})));
endmodule

// File: tb/pfx_adder16_tb_top.sv
module pfx_adder16_tb_top;
  localparam int NT = 10;
  localparam int NR = 240;
  localparam int N  = NT + NR;

  // {a, b, expected 17-bit sum}
  localparam logic [48:0] VEC [NT] = '{
    {16'h0000, 16'h0000, 17'h00000},  // R3 no carries
    {16'hFFFF, 16'h0001, 17'h10000},  // R8 full ripple
    {16'hFFFF, 16'hFFFF, 17'h1FFFE},
    {16'h8000, 16'h8000, 17'h10000},  // R5 top-bit carry only
    {16'h1234, 16'h4321, 17'h05555},
    {16'h000F, 16'h0001, 17'h00010},  // R4 nibble carry
    {16'h00FF, 16'h0001, 17'h00100},
    {16'h5555, 16'hAAAA, 17'h0FFFF},  // R3 propagate only
    {16'h7FFF, 16'h0001, 17'h08000},
    {16'hAAAA, 16'hAAAA, 17'h15554}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] a_in, b_in;
  logic        out_valid;
  logic [15:0] sum_out;
  logic        carry_out;

  int n_checks = 0;
  int n_fail   = 0;

  logic        exp_v [N];
  logic [16:0] exp_s [N];
  logic [15:0] ops_a [N];
  logic [15:0] ops_b [N];

  always #10 clk = ~clk;

  pfx_adder16 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .sum_out(sum_out), .carry_out(carry_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] a, input logic [15:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    in_valid = 1'b0; a_in = ~a; b_in = ~b;
    repeat (3) @(negedge clk);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {15'd0, carry_out, sum_out}, {15'd0, ({1'b0, a} + {1'b0, b})});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    chk("R6 in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 after release", {31'd0, out_valid}, 32'd0);

    // Build the stream: table back-to-back, then random with idle gaps
    for (int i = 0; i < N; i++) begin
      if (i < NT) begin
        ops_a[i] = VEC[i][48:33];
        ops_b[i] = VEC[i][32:17];
        exp_s[i] = VEC[i][16:0];
        exp_v[i] = 1'b1;
      end else begin
        ops_a[i] = 16'($urandom);
        ops_b[i] = 16'($urandom);
        exp_s[i] = {1'b0, ops_a[i]} + {1'b0, ops_b[i]};
        exp_v[i] = (($urandom % 4) != 0);
      end
    end

    for (int i = 0; i < N + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk((i - 4 < NT) ? "R2 table valid" : "R7 random valid",
            {31'd0, out_valid}, {31'd0, exp_v[i-4]});
        if (exp_v[i-4])
          chk((i - 4 < NT) ? "R1 table sum" : "R1 random sum",
              {15'd0, carry_out, sum_out}, {15'd0, exp_s[i-4]});
      end
      if (i < N) begin
        in_valid = exp_v[i];
        a_in     = ops_a[i];
        b_in     = ops_b[i];
      end else begin
        in_valid = 1'b0;
      end
    end

    // Directed corner cases
    run_one(16'hFFFF, 16'h0001, "R8 full ripple");
    run_one(16'h5555, 16'hAAAA, "R3 propagate only");
    run_one(16'h0000, 16'h0000, "R3 zero operands");
    run_one(16'h000F, 16'h0001, "R4 nibble carry");
    run_one(16'h8000, 16'h8000, "R5 carry-out only");

    // R7: idle cycles with changing operands do not disturb a result in flight
    @(negedge clk);
    in_valid = 1'b1; a_in = 16'h1234; b_in = 16'h0FF0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; a_in = 16'(k * 16'h1111); b_in = 16'hFFFF;
    end
    chk("R7 held result valid", {31'd0, out_valid}, 32'd1);
    chk("R7 held result sum", {15'd0, carry_out, sum_out}, 32'h00002224);
    @(negedge clk);
    chk("R7 idle slot", {31'd0, out_valid}, 32'd0);

    // R6: reset asserted with operations in flight
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; a_in = 16'(k + 1); b_in = 16'h0100;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R6 async clear", {31'd0, out_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R6 flushed", {31'd0, out_valid}, 32'd0);
    end
    run_one(16'hFFFF, 16'h0001, "R8 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule